// File: doc/BRIEF.md
# Two-Wire Register Front End for a Digital Potentiometer

This block is the serial slave side of a single-channel digital potentiometer controller. It runs on a system clock and oversamples the two-wire bus lines. It detects START and STOP, shifts bytes in MSB first and answers with acknowledge bits. It drives the data line only through an open-drain output enable. A transfer addresses the device with an identification byte, selects one of three registers with an address byte, and then writes one data byte or reads data back after a repeated START.

The register map holds three locations. Address 0 is the wiper position. Address 1 is the mode selection, which is kept in non-volatile storage. Address 2 is the access control register. The VOL bit in the control register decides whether address 0 reaches the live wiper only or the stored power-on value. A write to the stored value updates the wiper as well. Non-volatile writes go out as a one-cycle strobe to a separate storage controller, and that controller reports a busy flag back. While the flag is high, every register write is refused, although the bytes are still acknowledged.

Top module: `pot_i2c_regif`

## Requirements
- R1: The slave responds only to the 7-bit address 0,1,0,1,0,S,0 (MSB first), where S is the level on `addr_strap_i`; that is byte 50h or 54h with R/W clear. A mismatching identification byte gets no ACK, and the rest of the transfer up to the next START is ignored.
- R2: A write is START, identification (R/W=0), address byte, data byte, STOP, and each of the three bytes is ACKed (SDA pulled low in the ninth clock). The data takes effect only after its ACK clock ends. A transfer stopped before that point changes nothing.
- R3: Further data bytes after the first one in a write are not ACKed and change no register.
- R4: A read is START, identification (W), address byte, repeated START, identification (R=1). The register byte is returned MSB first for as long as the master ACKs. The address does not auto-increment, so every byte is the same register. A master NACK ends the read and releases SDA.
- R5: With VOL=1, a write to address 0 sets `wiper_o` to data bits 6:0, ignores bit 7 and issues no non-volatile strobe. A read of address 0 returns {0, wiper}.
- R6: With VOL=0, a write to address 0 sets `wiper_o` and pulses `nv_we_o` for one cycle with `nv_sel_o`=0 and `nv_wdata_o`={0, data[6:0]}. A read of address 0 returns {0, `nv_ivr_i`}.
- R7: The control register at address 2 reads {VOL, ACT, BUSY, 00000}. VOL is bit 7. ACT is bit 6, and ACT=0 drives `shutdown_o` high. BUSY is bit 5 and mirrors `nv_busy_i`; it cannot be written. Bits 4..0 read 0. Reset gives VOL=0 and ACT=1, so the register reads 40h.
- R8: A write to address 1 pulses `nv_we_o` with `nv_sel_o`=1 and `nv_wdata_o`={data[7:6], 000000}. A read returns {`nv_mode_i`, 000000}, so reserved bits 5..0 read 0.
- R9: While `nv_busy_i` is 1, writes to every address are refused: the wiper, the control register and `nv_we_o` do not change. The bytes are still ACKed.
- R10: A write to an address above 2 has no effect, and a read of such an address returns 00h.
- R11: After reset, `wiper_o` is 40h, `shutdown_o` is 0 and `sda_oe_o` is 0.
- R12: `sda_oe_o` is asserted only after an SCL falling edge, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_strap_i | input | 1 | Address strap, bit 1 of the slave address |
| nv_busy_i | input | 1 | Non-volatile write in progress |
| nv_ivr_i | input | 7 | Stored power-on wiper value |
| nv_mode_i | input | 2 | Stored mode select bits |
| nv_we_o | output | 1 | One-cycle non-volatile write strobe |
| nv_sel_o | output | 1 | Strobe target: 0 power-on value, 1 mode select |
| nv_wdata_o | output | 8 | Data for the non-volatile write |
| wiper_o | output | 7 | Current wiper position |
| shutdown_o | output | 1 | Potentiometer shut down |

## Verification
The bench sends identification bytes with the strap at both levels, so a decoder that ignores the strap or compares the wrong bits is seen to ACK the wrong device. It cuts a write off in the middle of the data byte and sends a second data byte, so a design that commits too early or accepts extra bytes is seen to move the wiper. It starts several writes while the storage controller is busy and reads the control register during that window, which shows a design that lets writes through or shows a stale BUSY bit. Two-byte reads show any auto-increment, and reads of address 0 under both VOL settings show a source mux that picks the wrong input.

// File: rtl/pot_i2c_pkg.sv
`timescale 1ns/1ps
package pot_i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ID_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_WSKIP, ST_RDATA, ST_RACK
  } i2c_st_e;

  localparam logic [7:0] REG_WIPER = 8'd0;
  localparam logic [7:0] REG_MODE  = 8'd1;
  localparam logic [7:0] REG_CTRL  = 8'd2;

  localparam int CTRL_VOL_BIT  = 7;
  localparam int CTRL_ACT_BIT  = 6;
  localparam int CTRL_BUSY_BIT = 5;

  localparam logic NV_SEL_INIT = 1'b0;
  localparam logic NV_SEL_MODE = 1'b1;
endpackage

// File: rtl/pot_i2c_sync.sv
`timescale 1ns/1ps
module pot_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_ff[STAGES-1];
      sda_p <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/pot_i2c_slave_fsm.sv
`timescale 1ns/1ps
module pot_i2c_slave_fsm
  import pot_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_BASE  = 7'h28,
  parameter int         STRAP_POS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       strap_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] wr_data_o,
  output logic       commit_o
);
  i2c_st_e    st;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       is_read;
  logic       mst_ack;
  logic [6:0] own_addr;
  logic       id_match;
  logic       byte_done;

  always_comb begin
    own_addr            = DEV_BASE;
    own_addr[STRAP_POS] = strap_i;
  end

  assign id_match  = (shreg[7:1] == own_addr);
  assign byte_done = scl_fall_i && (bitcnt == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      is_read    <= 1'b0;
      mst_ack    <= 1'b0;
      sda_oe_o   <= 1'b0;
      reg_addr_o <= '0;
      wr_data_o  <= '0;
      commit_o   <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (start_i) begin
        st       <= ST_ID;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_ID, ST_ADDR, ST_WDATA: begin
            if (scl_rise_i) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (st == ST_ID) begin
                if (id_match) begin
                  sda_oe_o <= 1'b1;
                  is_read  <= shreg[0];
                  st       <= ST_ID_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_ADDR) begin
                sda_oe_o   <= 1'b1;
                reg_addr_o <= shreg;
                st         <= ST_ADDR_ACK;
              end else begin
                sda_oe_o  <= 1'b1;
                wr_data_o <= shreg;
                st        <= ST_WDATA_ACK;
              end
            end
          end
          ST_ID_ACK: begin
            if (scl_fall_i) begin
              if (is_read) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                bitcnt   <= '0;
                st       <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_ADDR;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              st       <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              commit_o <= 1'b1;
              st       <= ST_WSKIP;
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (bitcnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                st       <= ST_RACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mst_ack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mst_ack) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                bitcnt   <= '0;
                st       <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pot_regs.sv
`timescale 1ns/1ps
module pot_regs
  import pot_i2c_pkg::*;
#(
  parameter int                 WIPER_W   = 7,
  parameter logic [WIPER_W-1:0] WIPER_RST = 7'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               nv_busy_i,
  input  logic [WIPER_W-1:0] nv_ivr_i,
  input  logic [1:0]         nv_mode_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               shutdown_o,
  output logic               nv_we_o,
  output logic               nv_sel_o,
  output logic [7:0]         nv_wdata_o,
  output logic [7:0]         rdata_o
);
  localparam int PAD = 8 - WIPER_W;

  logic vol, active, wr_ok;

  assign wr_ok = commit_i & ~nv_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o    <= WIPER_RST;
      vol        <= 1'b0;
      active     <= 1'b1;
      nv_we_o    <= 1'b0;
      nv_sel_o   <= NV_SEL_INIT;
      nv_wdata_o <= '0;
    end else begin
      nv_we_o <= 1'b0;
      if (wr_ok) begin
        case (addr_i)
          REG_WIPER: begin
            wiper_o <= wdata_i[WIPER_W-1:0];
            if (!vol) begin
              nv_we_o    <= 1'b1;
              nv_sel_o   <= NV_SEL_INIT;
              nv_wdata_o <= {{PAD{1'b0}}, wdata_i[WIPER_W-1:0]};
            end
          end
          REG_MODE: begin
            nv_we_o    <= 1'b1;
            nv_sel_o   <= NV_SEL_MODE;
            nv_wdata_o <= {wdata_i[7:6], 6'b0};
          end
          REG_CTRL: begin
            vol    <= wdata_i[CTRL_VOL_BIT];
            active <= wdata_i[CTRL_ACT_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_WIPER: rdata_o = {{PAD{1'b0}}, (vol ? wiper_o : nv_ivr_i)};
      REG_MODE:  rdata_o = {nv_mode_i, 6'b0};
      REG_CTRL: begin
        rdata_o[CTRL_VOL_BIT]  = vol;
        rdata_o[CTRL_ACT_BIT]  = active;
        rdata_o[CTRL_BUSY_BIT] = nv_busy_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign shutdown_o = ~active;
endmodule

// File: rtl/pot_i2c_regif.sv
`timescale 1ns/1ps
module pot_i2c_regif #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_BASE    = 7'h28,
  parameter int         STRAP_POS   = 1,
  parameter int         WIPER_W     = 7,
  parameter logic [WIPER_W-1:0] WIPER_RST = 7'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               addr_strap_i,
  input  logic               nv_busy_i,
  input  logic [WIPER_W-1:0] nv_ivr_i,
  input  logic [1:0]         nv_mode_i,
  output logic               nv_we_o,
  output logic               nv_sel_o,
  output logic [7:0]         nv_wdata_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               shutdown_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] reg_addr, wr_data, rd_data;
  logic commit;

  pot_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  pot_i2c_slave_fsm #(.DEV_BASE(DEV_BASE), .STRAP_POS(STRAP_POS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .strap_i    (addr_strap_i),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr),
    .wr_data_o  (wr_data),
    .commit_o   (commit)
  );

  pot_regs #(.WIPER_W(WIPER_W), .WIPER_RST(WIPER_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .addr_i     (reg_addr),
    .wdata_i    (wr_data),
    .nv_busy_i  (nv_busy_i),
    .nv_ivr_i   (nv_ivr_i),
    .nv_mode_i  (nv_mode_i),
    .wiper_o    (wiper_o),
    .shutdown_o (shutdown_o),
    .nv_we_o    (nv_we_o),
    .nv_sel_o   (nv_sel_o),
    .nv_wdata_o (nv_wdata_o),
    .rdata_o    (rd_data)
  );
endmodule

// File: rtl/pot_i2c_regif_chk.sv
`timescale 1ns/1ps
module pot_i2c_regif_chk #(
  parameter int WIPER_W = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_s_i,
  input logic               sda_oe_i,
  input logic               nv_we_i,
  input logic               nv_busy_i,
  input logic [WIPER_W-1:0] wiper_i,
  input logic               shutdown_i
);
  assert_nv_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_i |=> !nv_we_i);

  assert_nv_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_i |-> !$past(nv_busy_i));

  assert_wiper_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_i) |-> !$past(nv_busy_i));

  assert_shdn_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shutdown_i) |-> !$past(nv_busy_i));

  assert_drive_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !$past(scl_s_i));
endmodule

bind pot_i2c_regif pot_i2c_regif_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .sda_oe_i   (sda_oe_o),
  .nv_we_i    (nv_we_o),
  .nv_busy_i  (nv_busy_i),
  .wiper_i    (wiper_o),
  .shutdown_i (shutdown_o)
);

// File: tb/pot_i2c_regif_tb_top.sv
`timescale 1ns/1ps
module pot_i2c_regif_tb_top;
  localparam logic [6:0] DEV0 = 7'h28;
  localparam logic [6:0] DEV1 = 7'h2A;
  localparam int BUSY_CYC = 10000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, sda_line;
  logic nv_busy, nv_we, nv_sel;
  logic [7:0] nv_wdata;
  logic [6:0] wiper, ivr_m;
  logic [1:0] mode_m;
  logic shutdown;
  int busy_cnt, nv_cnt;
  int checks = 0, errors = 0, drive_hi = 0;
  logic oe_prev;

  assign sda_line = sda_m & ~sda_oe;
  assign nv_busy  = (busy_cnt != 0);

  pot_i2c_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_strap_i(strap), .nv_busy_i(nv_busy),
    .nv_ivr_i(ivr_m), .nv_mode_i(mode_m), .nv_we_o(nv_we), .nv_sel_o(nv_sel),
    .nv_wdata_o(nv_wdata), .wiper_o(wiper), .shutdown_o(shutdown)
  );

  // storage controller model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= 0; nv_cnt <= 0; ivr_m <= 7'h40; mode_m <= 2'b00;
    end else if (nv_we) begin
      busy_cnt <= BUSY_CYC;
      nv_cnt   <= nv_cnt + 1;
      if (!nv_sel) ivr_m <= nv_wdata[6:0];
      else mode_m <= nv_wdata[7:6];
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  // R12 monitor: output enable rising while SCL is high
  always @(posedge clk) begin
    if (sda_oe && !oe_prev && scl_m && rst_n) drive_hi++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic send_ack);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(~send_ack);
  endtask

  task automatic reg_wr(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                        output logic [2:0] acks);
    i2c_start();
    wbyte({dev, 1'b0}, acks[2]);
    wbyte(a, acks[1]);
    wbyte(d, acks[0]);
    i2c_stop();
  endtask

  task automatic reg_rd(input logic [6:0] dev, input logic [7:0] a,
                        output logic [7:0] b0, output logic [7:0] b1);
    logic k0, k1, k2;
    i2c_start();
    wbyte({dev, 1'b0}, k0);
    wbyte(a, k1);
    i2c_start();
    wbyte({dev, 1'b1}, k2);
    rbyte(b0, 1'b1);
    rbyte(b1, 1'b0);
    i2c_stop();
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] b0, b1;
    chk("R11 wiper", int'(wiper), 'h40);
    chk("R11 shutdown", int'(shutdown), 0);
    chk("R11 sda_oe", int'(sda_oe), 0);
    reg_rd(DEV0, 8'd2, b0, b1);
    chk("R7 ctrl reset", int'(b0), 'h40);
  endtask

  task automatic t_id_match();
    logic [2:0] acks;
    logic [7:0] b0, b1;
    reg_wr(DEV1, 8'd2, 8'hC0, acks);
    chk("R1 wrong strap no ack", int'(acks), 0);
    reg_wr(7'h68, 8'd2, 8'hC0, acks);
    chk("R1 wrong high bits no ack", int'(acks), 0);
    reg_rd(DEV0, 8'd2, b0, b1);
    chk("R1 ignored transfer", int'(b0), 'h40);
    reg_wr(DEV0, 8'd2, 8'hC0, acks);
    chk("R2 three acks", int'(acks), 7);
    reg_rd(DEV0, 8'd2, b0, b1);
    chk("R7 ctrl write", int'(b0), 'hC0);
  endtask

  task automatic t_vol_write();
    logic [2:0] acks;
    logic [7:0] b0, b1;
    int n0 = nv_cnt;
    reg_wr(DEV0, 8'd0, 8'hA5, acks);
    chk("R5 wiper bit7 dropped", int'(wiper), 'h25);
    chk("R5 no nv strobe", nv_cnt, n0);
    reg_rd(DEV0, 8'd0, b0, b1);
    chk("R4 first byte", int'(b0), 'h25);
    chk("R4 no auto-increment", int'(b1), 'h25);
    chk("R4 released after nack", int'(sda_oe), 0);
  endtask

  task automatic t_extra_and_abort();
    logic k, k2;
    i2c_start();
    wbyte({DEV0, 1'b0}, k); wbyte(8'd0, k); wbyte(8'h05, k);
    wbyte(8'h7A, k2);
    i2c_stop();
    chk("R3 extra byte nack", int'(k2), 0);
    chk("R3 first byte kept", int'(wiper), 'h05);
    i2c_start();
    wbyte({DEV0, 1'b0}, k); wbyte(8'd0, k);
    for (int i = 0; i < 4; i++) bit_w(1'b1);
    i2c_stop();
    chk("R2 aborted write", int'(wiper), 'h05);
  endtask

  task automatic t_nv_busy();
    logic [2:0] acks;
    logic [7:0] b0, b1;
    int n0;
    reg_wr(DEV0, 8'd2, 8'h40, acks);
    n0 = nv_cnt;
    reg_wr(DEV0, 8'd0, 8'h11, acks);
    chk("R6 wiper follows", int'(wiper), 'h11);
    chk("R6 one strobe", nv_cnt, n0 + 1);
    chk("R6 stored value", int'(ivr_m), 'h11);
    reg_rd(DEV0, 8'd2, b0, b1);
    chk("R7 busy bit", int'(b0), 'h60);
    reg_wr(DEV0, 8'd0, 8'h33, acks);
    chk("R9 still acked", int'(acks), 7);
    chk("R9 wiper held", int'(wiper), 'h11);
    chk("R9 no strobe", nv_cnt, n0 + 1);
    reg_wr(DEV0, 8'd2, 8'h80, acks);
    chk("R9 shutdown held", int'(shutdown), 0);
    reg_rd(DEV0, 8'd2, b0, b1);
    chk("R9 ctrl held", int'(b0), 'h60);
    chk("R9 still busy", int'(nv_busy), 1);
    wait_idle();
    reg_rd(DEV0, 8'd0, b0, b1);
    chk("R6 read stored value", int'(b0), 'h11);
  endtask

  task automatic t_mode();
    logic [2:0] acks;
    logic [7:0] b0, b1;
    int n0 = nv_cnt;
    reg_wr(DEV0, 8'd1, 8'hFF, acks);
    chk("R8 strobe", nv_cnt, n0 + 1);
    chk("R8 stored bits", int'(mode_m), 3);
    wait_idle();
    reg_rd(DEV0, 8'd1, b0, b1);
    chk("R8 reserved read 0", int'(b0), 'hC0);
    reg_wr(DEV0, 8'd1, 8'h7F, acks);
    wait_idle();
    reg_rd(DEV0, 8'd1, b0, b1);
    chk("R8 second value", int'(b0), 'h40);
  endtask

  task automatic t_shutdown();
    logic [2:0] acks;
    logic [7:0] b0, b1;
    reg_wr(DEV0, 8'd2, 8'h9F, acks);
    chk("R7 shutdown on", int'(shutdown), 1);
    reg_rd(DEV0, 8'd2, b0, b1);
    chk("R7 low bits read 0", int'(b0), 'h80);
    reg_wr(DEV0, 8'd2, 8'hC0, acks);
    chk("R7 shutdown off", int'(shutdown), 0);
  endtask

  task automatic t_unmapped();
    logic [2:0] acks;
    logic [7:0] b0, b1;
    int n0 = nv_cnt;
    logic [6:0] w0 = wiper;
    reg_wr(DEV0, 8'd5, 8'h3C, acks);
    chk("R10 wiper unchanged", int'(wiper), int'(w0));
    chk("R10 no strobe", nv_cnt, n0);
    reg_rd(DEV0, 8'd5, b0, b1);
    chk("R10 read zero", int'(b0), 0);
  endtask

  task automatic t_strap();
    logic [2:0] acks;
    strap = 1'b1;
    repeat (5) @(negedge clk);
    reg_wr(DEV0, 8'd0, 8'h2B, acks);
    chk("R1 strap high old addr", int'(acks), 0);
    reg_wr(DEV1, 8'd0, 8'h2B, acks);
    chk("R1 strap high acked", int'(acks), 7);
    chk("R1 strap high write", int'(wiper), 'h2B);
    strap = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_id_match();
    t_vol_write();
    t_extra_and_abort();
    t_nv_busy();
    t_mode();
    t_shutdown();
    t_unmapped();
    t_strap();
    chk("R12 no drive while scl high", drive_hi, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule